// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Register

This block is a small memory-mapped general-purpose I/O port for an 8-bit microcontroller bus. Every implemented bit has an output value register and a direction bit. A processor writes and reads both through two fixed bus addresses. The port presents to the pad ring an output value and an output enable for each bit. It samples the pad inputs through a two-stage synchroniser.

One bit is wired as input-only. Its synchronised level also drives a capture signal towards a timer. That bit stays readable through the data register at any time. The direction bits return to input on reset. The output value register is not reset, so software can preload output values before it turns any pin into an output.

Reads are registered. The read strobe in one cycle puts the selected register on the read data bus after the next clock edge, and the bus then holds that value until the next strobe. A write and a read in the same cycle see the register contents from before the write.

Top module: `gpio_port`

## Requirements
- R1: A bit whose direction bit is 1 has `pad_oe` high, and `pad_out` always carries that bit's output value register. A bit whose direction bit is 0 has `pad_oe` low.
- R2: Reset clears every direction bit. After reset `pad_oe` is all zero and a read of the direction register returns 0.
- R3: Reset leaves the output value register unchanged. A value written before reset appears on `pad_out`, and reads back once the bit is made an output again.
- R4: A write to the data address updates the output value register for every implemented bit, including bits in input mode. `pad_out` shows the new value one cycle after the write.
- R5: A data read returns, for each bit, the output value register when the bit's direction is 1 and the synchronised pad level when it is 0.
- R6: The direction register is written at its address and reads back what was written.
- R7: The input-only bit (bit 1 by default) ignores direction writes. Its `pad_oe` stays low and its direction bit reads back as 0.
- R8: The capture bit's synchronised pad level is readable through the data register and appears on `cap_out` regardless of any register setting.
- R9: The data register is at address 0x03 and the direction register at 0x07. Writes to any other address change nothing, and reads of any other address return 0.
- R10: Bit positions at or above the port width (bits 7:2 by default) read as 0 in both registers, and writes to them are ignored.
- R11: A pad level change reaches `cap_out` and the read path after two clock edges.
- R12: `bus_rdata` updates only on the edge after `bus_rd` is high and holds otherwise. A read in the same cycle as a write to the same register returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 2 | Pad input levels (asynchronous) |
| pad_out | output | 2 | Output value register towards the pads |
| pad_oe | output | 2 | Per-bit pad output enable |
| cap_out | output | 1 | Synchronised capture-bit level for the timer |

## Verification
The collision of interest is a bus write and a bus read hitting the same register in the same cycle. The read must return the old contents while the write still takes effect. The bench raises both strobes in one cycle on the data and on the direction register. It then compares the returned value with the pre-write contents, and a second read with the newly written value. A related overlap is a direction write landing while pin levels change. The bench checks that the read value switches between latch and pin per bit, only after the direction write has taken effect.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int           W            = 2,
  parameter logic [W-1:0] IN_ONLY_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);
  // Output value register: deliberately without reset.
  always_ff @(posedge clk) begin
    if (wr_data) latch_q <= wdata;
  end

  // Direction bits: cleared by reset, input-only positions never set.
  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '0;
    else if (wr_dir) dir_q <= wdata & ~IN_ONLY_MASK;
  end
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_port_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic [W-1:0]     latch_q,
  input  logic [W-1:0]     dir_q,
  input  logic [W-1:0]     pins,
  output logic [BUS_W-1:0] rdata
);
  logic [W-1:0]     port_view;
  logic [BUS_W-1:0] rd_next;

  // Per bit: output mode shows the latch, input mode shows the pin.
  assign port_view = (latch_q & dir_q) | (pins & ~dir_q);

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_DATA: rd_next[W-1:0] = port_view;
      SEL_DIR:  rd_next[W-1:0] = dir_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int                BUS_W        = 8,
  parameter int                ADDR_W       = 8,
  parameter int                PORT_W       = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR    = 8'h03,
  parameter logic [ADDR_W-1:0] DIR_ADDR     = 8'h07,
  parameter int                CAP_BIT      = 1,
  parameter logic [PORT_W-1:0] IN_ONLY_MASK = 2'b10,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic              cap_out
);
  reg_sel_e          sel;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] pins_sync;

  always_comb begin
    if (bus_addr == DATA_ADDR)     sel = SEL_DATA;
    else if (bus_addr == DIR_ADDR) sel = SEL_DIR;
    else                           sel = SEL_NONE;
  end

  generate
    if (PORT_W < BUS_W) begin : g_wide_bus
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[BUS_W-1:PORT_W];
    end
  endgenerate

  gpio_in_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pad_in),
    .dout(pins_sync)
  );

  gpio_regs #(.W(PORT_W), .IN_ONLY_MASK(IN_ONLY_MASK)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_data(bus_wr && (sel == SEL_DATA)),
    .wr_dir (bus_wr && (sel == SEL_DIR)),
    .wdata  (bus_wdata[PORT_W-1:0]),
    .latch_q(latch_q),
    .dir_q  (dir_q)
  );

  gpio_rd_path #(.BUS_W(BUS_W), .W(PORT_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (bus_rd),
    .sel    (sel),
    .latch_q(latch_q),
    .dir_q  (dir_q),
    .pins   (pins_sync),
    .rdata  (bus_rdata)
  );

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;
  assign cap_out = pins_sync[CAP_BIT];
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int                BUS_W        = 8,
  parameter int                ADDR_W       = 8,
  parameter int                PORT_W       = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR    = 8'h03,
  parameter int                CAP_BIT      = 1,
  parameter logic [PORT_W-1:0] IN_ONLY_MASK = 2'b10
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [PORT_W-1:0] pad_in,
  input logic [PORT_W-1:0] pad_out,
  input logic [PORT_W-1:0] pad_oe,
  input logic              cap_out
);
  logic [1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst)                run_cnt <= '0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  p_dir_clear_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0));

  p_latch_write_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == DATA_ADDR) |=> (pad_out == $past(bus_wdata[PORT_W-1:0])));

  p_in_only_oe_r7: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & IN_ONLY_MASK) == '0);

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:PORT_W] == '0);

  p_sync_delay_r11: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 2'd2) |-> (cap_out == $past(pad_in[CAP_BIT], 2)));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_port gpio_port_chk #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .PORT_W(PORT_W), .DATA_ADDR(DATA_ADDR),
  .CAP_BIT(CAP_BIT), .IN_ONLY_MASK(IN_ONLY_MASK)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .cap_out(cap_out)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam logic [7:0] A_DATA = 8'h03;
  localparam logic [7:0] A_DIR  = 8'h07;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [1:0] pad_in = '0;
  logic [1:0] pad_out;
  logic [1:0] pad_oe;
  logic       cap_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .cap_out(cap_out)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_keeps_latch();
    logic [7:0] v;
    wr(A_DATA, 8'h01);
    wr(A_DIR, 8'h01);
    check({6'd0, pad_oe}, 8'h01, "R1 oe set by dir");
    check({6'd0, pad_out}, 8'h01, "R1 pad_out from latch");
    pulse_reset();
    check({6'd0, pad_oe}, 8'h00, "R2 oe cleared by reset");
    rd(A_DIR, v);
    check(v, 8'h00, "R2 dir reads 0 after reset");
    check({6'd0, pad_out}, 8'h01, "R3 latch kept over reset");
    wr(A_DIR, 8'h01);
    pad_in = 2'b00;
    repeat (3) @(negedge clk);
    rd(A_DATA, v);
    check(v, 8'h01, "R3 latch reads back after reset");
  endtask

  task automatic t_input_mode_write();
    logic [7:0] v;
    wr(A_DIR, 8'h00);
    wr(A_DATA, 8'h00);
    check({6'd0, pad_out}, 8'h00, "R4 latch written in input mode");
    check({6'd0, pad_oe}, 8'h00, "R1 oe low in input mode");
    pad_in = 2'b11;
    repeat (3) @(negedge clk);
    rd(A_DATA, v);
    check(v, 8'h03, "R5 input mode reads pins");
    wr(A_DIR, 8'h01);
    rd(A_DATA, v);
    check(v, 8'h02, "R5 mixed latch and pin");
  endtask

  task automatic t_dir_readback();
    logic [7:0] v;
    wr(A_DIR, 8'hFF);
    rd(A_DIR, v);
    check(v, 8'h01, "R6 R7 R10 dir readback");
    check({6'd0, pad_oe}, 8'h01, "R7 input-only oe low");
    wr(A_DIR, 8'h00);
    rd(A_DIR, v);
    check(v, 8'h00, "R6 dir readback cleared");
  endtask

  task automatic t_capture();
    logic [7:0] v;
    wr(A_DIR, 8'hFF);
    pad_in[1] = 1'b0;
    repeat (3) @(negedge clk);
    check({7'd0, cap_out}, 8'h00, "R8 cap low");
    pad_in[1] = 1'b1;
    @(negedge clk);
    check({7'd0, cap_out}, 8'h00, "R11 cap after one edge");
    @(negedge clk);
    check({7'd0, cap_out}, 8'h01, "R11 cap after two edges");
    rd(A_DATA, v);
    check(v & 8'h02, 8'h02, "R8 cap bit readable via data");
  endtask

  task automatic t_other_addr();
    logic [7:0] v;
    wr(A_DIR, 8'h01);
    wr(A_DATA, 8'h00);
    wr(8'h05, 8'hFF);
    wr(8'h04, 8'hFF);
    check({6'd0, pad_out}, 8'h00, "R9 stray write leaves latch");
    check({6'd0, pad_oe}, 8'h01, "R9 stray write leaves dir");
    rd(8'h05, v);
    check(v, 8'h00, "R9 stray read returns 0");
  endtask

  task automatic t_upper_bits();
    logic [7:0] v;
    wr(A_DIR, 8'h01);
    wr(A_DATA, 8'hFD);
    rd(A_DATA, v);
    check(v & 8'hFD, 8'h01, "R10 data upper bits read 0");
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    wr(A_DIR, 8'h01);
    wr(A_DATA, 8'h00);
    bus_addr = A_DATA; bus_wdata = 8'h01; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check(bus_rdata & 8'h01, 8'h00, "R12 same-cycle data read old");
    repeat (2) @(negedge clk);
    check(bus_rdata & 8'h01, 8'h00, "R12 rdata held without strobe");
    rd(A_DATA, v);
    check(v & 8'h01, 8'h01, "R12 later read new");
    bus_addr = A_DIR; bus_wdata = 8'h00; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check(bus_rdata, 8'h01, "R12 same-cycle dir read old");
    check({6'd0, pad_oe}, 8'h00, "R12 dir write took effect");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(bus_rdata, 8'h00, "R2 rdata after reset");
    check({6'd0, pad_oe}, 8'h00, "R2 oe after reset");
    t_reset_keeps_latch();
    t_input_mode_write();
    t_dir_readback();
    t_capture();
    t_other_addr();
    t_upper_bits();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule